// File: doc/BRIEF.md
# Two-Cycle Main Memory Unit

This block is the main store of a small 16-bit microprogrammed processor. It holds 4096 words of 16 bits. Two holding registers sit between the datapath and the array. The address holding register (MAR) supplies the address of every access. The buffer register (MBR) carries data in both directions.

The datapath first loads the MAR, and for a write it also loads the MBR. It then raises a read or write request. To model slow memory, an access takes effect only once the same request has been sampled on two consecutive clock edges. A held request therefore completes on every second edge.

Illegal operations set a sticky error flag and touch neither the storage nor the MBR. There are two of them: an address with any of its upper bits set, and a read and a write requested together. A one-cycle done pulse marks each completed access.

Top module: `slow_mem_unit`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0, `err` is 0 and `mbr_q` is 0.
- R2: With `mbr_ld` high at a clock edge and no read completing at that edge, `mbr_q` equals `data_in` after that edge.
- R3: When `wr_req` is sampled high on two consecutive edges, the second edge stores `mbr_q` into the word selected by the MAR, and `done` is 1 for the cycle that follows.
- R4: When `rd_req` is sampled high on two consecutive edges, `mbr_q` shows the selected word after the second edge, in the same cycle that `done` is 1.
- R5: A request that is high for only one edge has no effect. No `done` follows, storage is unchanged, and a later access needs two fresh consecutive edges.
- R6: A request held high continuously completes on every second edge. `done` is never high for two cycles in a row.
- R7: `mar_ld` loads the MAR from `addr_in`. If bits 15:12 of the loaded value are nonzero, any access that reaches completion sets `err` instead. It raises no `done`, and it leaves both storage and `mbr_q` unchanged.
- R8: `rd_req` and `wr_req` sampled high at the same edge set `err`, access nothing and cancel any pending half-access.
- R9: `err` stays 1 until an edge where `err_clr` is high and no new error is raised, or until reset. A new error wins over a clear at the same edge.
- R10: Switching the request from read to write, or from write to read, between two edges restarts the two-edge count for the new kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_ld | input | 1 | Load the address holding register from `addr_in` |
| addr_in | input | 16 | Address from the datapath; bits 15:12 must be zero |
| mbr_ld | input | 1 | Load the buffer register from `data_in` |
| data_in | input | 16 | Data from the datapath |
| rd_req | input | 1 | Read request; must be held for two edges |
| wr_req | input | 1 | Write request; must be held for two edges |
| err_clr | input | 1 | Clear the sticky error flag |
| mbr_q | output | 16 | Buffer register contents |
| done | output | 1 | One-cycle pulse on a completed access |
| err | output | 1 | Sticky error flag |

## Verification
A corrupted pending-request state shows up at the ports within one edge. Either `done` arrives one cycle early or late, or it pulses twice in a row. A wrong MAR or write path stays hidden until the affected word is read back. For that reason every one of the 4096 words is written with a distinct arithmetic pattern and then read back. A wrong legality or error path shows up as `err` failing to rise on the very edge that should set it, or as a storage word or `mbr_q` that changes when it must not.

// File: rtl/slow_mem_pkg.sv
package slow_mem_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int ADDR_W_DEF = 12;
  localparam int PORT_W_DEF = 16;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_RD   = 2'd1,
    REQ_WR   = 2'd2
  } req_kind_t;
endpackage

// File: rtl/smu_mar.sv
module smu_mar #(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [PORT_W-1:0] addr_in,
  output logic [ADDR_W-1:0] mar_q,
  output logic              bad_q
);
  localparam int HI_W = PORT_W - ADDR_W;

  logic hi_nonzero;

  generate
    if (HI_W > 0) begin : g_hi
      assign hi_nonzero = |addr_in[PORT_W-1:ADDR_W];
    end else begin : g_nohi
      assign hi_nonzero = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      bad_q <= 1'b0;
    end else if (ld) begin
      mar_q <= addr_in[ADDR_W-1:0];
      bad_q <= hi_nonzero;
    end
  end
endmodule

// File: rtl/smu_req_timer.sv
module smu_req_timer
  import slow_mem_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_req,
  input  logic      wr_req,
  output logic      fire,
  output req_kind_t fire_kind,
  output logic      clash
);
  req_kind_t cur_kind;
  req_kind_t pend_kind;

  always_comb begin
    clash = rd_req & wr_req;
    if (clash)       cur_kind = REQ_NONE;
    else if (rd_req) cur_kind = REQ_RD;
    else if (wr_req) cur_kind = REQ_WR;
    else             cur_kind = REQ_NONE;
  end

  assign fire      = (cur_kind != REQ_NONE) && (pend_kind == cur_kind);
  assign fire_kind = cur_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_kind <= REQ_NONE;
    end else if (fire) begin
      pend_kind <= REQ_NONE;
    end else begin
      pend_kind <= cur_kind;
    end
  end
endmodule

// File: rtl/smu_store.sv
module smu_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/slow_mem_unit.sv
module slow_mem_unit
  import slow_mem_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int PORT_W = PORT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mar_ld,
  input  logic [PORT_W-1:0] addr_in,
  input  logic              mbr_ld,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              err_clr,
  output logic [DATA_W-1:0] mbr_q,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] mar;
  logic              mar_bad;
  logic              fire;
  req_kind_t         fire_kind;
  logic              clash;
  logic              go_rd, go_wr, bad_hit, err_set;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] mbr_hold;
  logic              mbr_from_mem;

  smu_mar #(.PORT_W(PORT_W), .ADDR_W(ADDR_W)) mar_i (
    .clk(clk), .rst(rst), .ld(mar_ld), .addr_in(addr_in),
    .mar_q(mar), .bad_q(mar_bad)
  );

  smu_req_timer timer_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
    .fire(fire), .fire_kind(fire_kind), .clash(clash)
  );

  assign go_rd   = fire && (fire_kind == REQ_RD) && !mar_bad;
  assign go_wr   = fire && (fire_kind == REQ_WR) && !mar_bad;
  assign bad_hit = fire && mar_bad;
  assign err_set = clash || bad_hit;

  smu_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .we(go_wr), .re(go_rd), .addr(mar),
    .wdata(mbr_q), .rdata(rd_word)
  );

  // MBR: a held value plus a select that points at the RAM read register,
  // so the array keeps a plain registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      mbr_hold     <= '0;
      mbr_from_mem <= 1'b0;
    end else if (go_rd) begin
      mbr_from_mem <= 1'b1;
    end else if (mbr_ld) begin
      mbr_hold     <= data_in;
      mbr_from_mem <= 1'b0;
    end else if (mbr_from_mem) begin
      mbr_hold     <= rd_word;
      mbr_from_mem <= 1'b0;
    end
  end

  assign mbr_q = mbr_from_mem ? rd_word : mbr_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= go_rd || go_wr;
      if (err_set)      err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/slow_mem_unit_chk.sv
module slow_mem_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              wr_req,
  input logic              mbr_ld,
  input logic              err_clr,
  input logic [DATA_W-1:0] mbr_q,
  input logic              done,
  input logic              err
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!done && !err && (mbr_q == '0)));

  assert_mbr_only_moves_on_cause_R4: assert property (@(posedge clk) disable iff (rst)
    !mbr_ld |=> ($stable(mbr_q) || done));

  assert_done_after_two_edges_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (($past(rd_req) && $past(rd_req, 2) && !$past(wr_req))
           || ($past(wr_req) && $past(wr_req, 2) && !$past(rd_req))));

  assert_done_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_clash_sets_err_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_req) |=> (err && !done));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);
endmodule

bind slow_mem_unit slow_mem_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
  .mbr_ld(mbr_ld), .err_clr(err_clr), .mbr_q(mbr_q),
  .done(done), .err(err)
);

// File: tb/slow_mem_unit_tb_top.sv
module slow_mem_unit_tb_top;
  localparam int WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mar_ld = 1'b0;
  logic [15:0] addr_in = '0;
  logic        mbr_ld = 1'b0;
  logic [15:0] data_in = '0;
  logic        rd_req = 1'b0;
  logic        wr_req = 1'b0;
  logic        err_clr = 1'b0;
  logic [15:0] mbr_q;
  logic        done;
  logic        err;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] model [WORDS];

  always #2 clk = ~clk;

  slow_mem_unit dut_i (
    .clk(clk), .rst(rst), .mar_ld(mar_ld), .addr_in(addr_in),
    .mbr_ld(mbr_ld), .data_in(data_in), .rd_req(rd_req), .wr_req(wr_req),
    .err_clr(err_clr), .mbr_q(mbr_q), .done(done), .err(err)
  );

  function automatic logic [15:0] pat(input int a, input int salt);
    return 16'((a * 40503 + salt * 977) ^ 16'h5A5A);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic do_d, input logic [15:0] d);
    mar_ld = 1'b1; addr_in = a; mbr_ld = do_d; data_in = d;
    tick();
    mar_ld = 1'b0; mbr_ld = 1'b0;
  endtask

  // request held for two edges; returns done and err seen after second edge
  task automatic access(input logic is_wr, output logic d_o, output logic e_o);
    rd_req = !is_wr; wr_req = is_wr;
    tick();
    chk("R3/R4 no early done", {15'd0, done}, 16'd0);
    tick();
    d_o = done; e_o = err;
    rd_req = 1'b0; wr_req = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic d, e;
    logic [15:0] keep;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 err",  {15'd0, err},  16'd0);
    chk("R1 mbr",  mbr_q, 16'd0);

    load(16'h0000, 1'b1, 16'hBEEF);
    chk("R2 mbr load", mbr_q, 16'hBEEF);

    // R3 sweep: write every word
    for (int a = 0; a < WORDS; a++) begin
      model[a] = pat(a, 1);
      load(16'(a), 1'b1, model[a]);
      access(1'b1, d, e);
      if (d !== 1'b1) chk("R3 write done", {15'd0, d}, 16'd1);
      n_checks++;
    end
    // R4 sweep: read back every word, descending order
    for (int a = WORDS - 1; a >= 0; a--) begin
      load(16'(a), 1'b1, 16'hFFFF ^ model[a]);
      rd_req = 1'b1;
      tick();
      tick();
      if (done !== 1'b1) chk("R4 read done", {15'd0, done}, 16'd1);
      if (mbr_q !== model[a]) chk("R4 read data", mbr_q, model[a]);
      n_checks++;
      rd_req = 1'b0;
      tick();
      chk("R4 mbr held after read", mbr_q, model[a]);
    end

    // R5: single-edge write has no effect
    load(16'd7, 1'b1, 16'h1111);
    wr_req = 1'b1; tick(); wr_req = 1'b0; tick();
    chk("R5 no done", {15'd0, done}, 16'd0);
    tick(); tick();
    chk("R5 no done later", {15'd0, done}, 16'd0);
    load(16'd7, 1'b0, 16'h0);
    access(1'b0, d, e);
    chk("R5 storage unchanged", mbr_q, model[7]);
    // fresh count after a dropped request
    load(16'd8, 1'b1, 16'h2222);
    wr_req = 1'b1; tick(); wr_req = 1'b0; tick();
    access(1'b1, d, e);
    chk("R5 restart needs two edges", {15'd0, d}, 16'd1);
    model[8] = 16'h2222;

    // R6: held read completes every second edge
    load(16'd9, 1'b0, 16'h0);
    rd_req = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk("R6 alternate done", {15'd0, done}, (k % 2 == 0) ? 16'd1 : 16'd0);
    end
    rd_req = 1'b0; tick();
    chk("R6 data", mbr_q, model[9]);

    // R10: read then write restarts count
    load(16'd10, 1'b1, 16'h3333);
    rd_req = 1'b1; tick();
    rd_req = 1'b0; wr_req = 1'b1; tick();
    chk("R10 no done on kind switch", {15'd0, done}, 16'd0);
    tick();
    chk("R10 done after fresh pair", {15'd0, done}, 16'd1);
    wr_req = 1'b0; tick();
    model[10] = 16'h3333;
    load(16'd10, 1'b1, 16'h0);
    access(1'b0, d, e);
    chk("R10 write landed", mbr_q, 16'h3333);

    // R7: illegal address
    load(16'h1005, 1'b1, 16'h4444);
    access(1'b0, d, e);
    chk("R7 bad read no done", {15'd0, d}, 16'd0);
    chk("R7 bad read err", {15'd0, e}, 16'd1);
    chk("R7 mbr unchanged", mbr_q, 16'h4444);
    access(1'b1, d, e);
    chk("R7 bad write no done", {15'd0, d}, 16'd0);
    load(16'h8FFF, 1'b0, 16'h0);
    access(1'b1, d, e);
    chk("R7 top bit bad", {15'd0, d}, 16'd0);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk("R9 clear", {15'd0, err}, 16'd0);
    load(16'd5, 1'b0, 16'h0);
    access(1'b0, d, e);
    chk("R7 storage 5 unchanged", mbr_q, model[5]);
    load(16'd4095, 1'b0, 16'h0);
    access(1'b0, d, e);
    chk("R7 storage 4095 unchanged", mbr_q, model[4095]);
    chk("R7 legal access no err", {15'd0, e}, 16'd0);

    // R8: clash cancels pending half-access
    load(16'd11, 1'b1, 16'h5555);
    keep = model[11];
    rd_req = 1'b1; tick();
    wr_req = 1'b1; tick();
    chk("R8 err", {15'd0, err}, 16'd1);
    chk("R8 no done", {15'd0, done}, 16'd0);
    wr_req = 1'b0; tick();
    chk("R8 pending cancelled", {15'd0, done}, 16'd0);
    tick();
    chk("R8 fresh pair completes", {15'd0, done}, 16'd1);
    chk("R8 storage unchanged", mbr_q, keep);
    rd_req = 1'b0; tick();

    // R9: sticky, set wins over clear
    repeat (3) tick();
    chk("R9 sticky", {15'd0, err}, 16'd1);
    err_clr = 1'b1; rd_req = 1'b1; wr_req = 1'b1; tick();
    chk("R9 set beats clear", {15'd0, err}, 16'd1);
    rd_req = 1'b0; wr_req = 1'b0; tick();
    chk("R9 cleared", {15'd0, err}, 16'd0);
    err_clr = 1'b0;

    // R1 again: reset mid-run
    load(16'h1000, 1'b1, 16'h7777);
    access(1'b0, d, e);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 err after reset", {15'd0, err}, 16'd0);
    chk("R1 mbr after reset", mbr_q, 16'd0);

    finish_run();
  end
endmodule